// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the target side of a two-wire serial memory holding 2048 bytes, grouped into eight blocks of 256 bytes. It takes the clock and data lines as plain inputs from the pads, brings them into the system clock domain, and pulls the data line low through a single output-enable signal (`sda_oe_o` high means drive low). The bus is oversampled, so the system clock must run many times faster than the bus clock.

A master addresses the block with a control byte that carries a fixed device tag, a block number and a read/write flag. A write supplies a word address inside the block followed by one or more data bytes. The bytes collect in a page buffer and are copied into the storage array during a self-timed busy interval of `WR_CYCLES` system clocks that starts at the stop condition. Reads return the byte at an internal 11-bit pointer and keep returning following bytes for as long as the master acknowledges. A write-protect input discards staged data at the stop condition.

Control is a single state machine. Its states are IDLE (bus free), CTRL (shifting in the control byte), CACK (acknowledging it), ADDR (shifting in the word address), AACK (acknowledging it), WDAT (shifting in a data byte), DACK (acknowledging a data byte), TX (shifting a byte out), RACK (sampling the master's acknowledge) and SKIP (not addressed; waiting for the bus to go free). Transitions: any state to IDLE on stop and to CTRL on start; CTRL to CACK on an accepted control byte, else to SKIP; CACK to TX for a read or to ADDR for a write; ADDR to AACK; AACK to WDAT; WDAT to DACK and DACK back to WDAT; TX to RACK after eight bits; RACK to TX on a master acknowledge or to SKIP on a master not-acknowledge. Every move except start and stop happens on a falling edge of the bus clock.

Top module: `sermem_slave`

## Requirements
- R1: After reset the data line is released, the state machine is idle and no write interval is running, so the first valid control byte is acknowledged.
- R2: A start is the data line falling while the clock line is high and a stop is the data line rising while the clock line is high; a stop always returns the block to idle, and the block changes its data-line drive only while the clock line is low (except when leaving a state on start or stop).
- R3: Bytes are shifted most-significant bit first; the block acknowledges an accepted control byte, the word address and every write data byte by pulling the data line low for the whole ninth clock pulse.
- R4: The control byte is bits [7:4] = 4'b1010, bits [3:1] = block number (address bits 10:8), bit [0] = 1 for read and 0 for write; a control byte with any other value in bits [7:4] is not acknowledged.
- R5: A write of one data byte followed by stop stores it at address {block, word address}.
- R6: A write accepts any number of data bytes; address bits 3:0 advance and wrap inside the 16-byte page, so byte 17 onward overwrites earlier buffer entries and the last byte written to a page slot wins.
- R7: A commit starts only on a stop that follows at least one complete data byte; it keeps the block busy for `WR_CYCLES` system clocks and changes only the page slots that received data.
- R8: While a commit is running, a control byte is not acknowledged; after it ends, a control byte is acknowledged again.
- R9: With the write-protect input high at the stop, data bytes are still acknowledged, the array is unchanged and no busy interval starts.
- R10: A random read (write control byte, word address, repeated start, read control byte) returns the byte at {block, word address}.
- R11: While the master acknowledges, a read returns successive bytes; the 11-bit pointer wraps from 0x7FF to 0x000.
- R12: A master not-acknowledge followed by stop ends a read and keeps the pointer one past the last byte sent; a later current-address read takes bits 10:8 from its control byte and returns the byte at that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wp_i | input | 1 | Write protect; high blocks commits |
| sda_oe_o | output | 1 | High pulls the data line low |

## Verification
The main function is tried with single-byte writes to scattered addresses in different blocks, each read back through a random read; this separates correct block decoding from a design that ignores bits 10:8 of the address. A page write of eighteen bytes starting mid-page tells a design that wraps inside the page and lets later bytes win from one that spills into the next page or keeps the first bytes. A single-byte write into an already full page checks that neighbouring slots survive the commit. Reads that cross 0x7FF, that stop with a not-acknowledge and then resume with a current-address read, and writes under write protect followed by an immediate control byte tell the pointer and busy handling apart from plausible wrong variants.

// File: rtl/sermem_pkg.sv
package sermem_pkg;

    // Fixed device tag carried in the upper nibble of the control byte.
    localparam logic [3:0] DEV_TAG = 4'b1010;

    // Number of block-select bits in the control byte.
    localparam int BLK_W = 3;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CACK,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_DACK,
        ST_TX,
        ST_RACK,
        ST_SKIP
    } bus_state_t;

endpackage

// File: rtl/sermem_bus_sync.sv
module sermem_bus_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_q;
    logic                   sda_q;

    // Synchroniser chains, idle bus level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_q  <= scl_sh[SYNC_STAGES-1];
            sda_q  <= sda_sh[SYNC_STAGES-1];
        end
    end

    assign scl_lvl   = scl_sh[SYNC_STAGES-1];
    assign sda_lvl   = sda_sh[SYNC_STAGES-1];
    assign scl_rise  =  scl_lvl & ~scl_q;
    assign scl_fall  = ~scl_lvl &  scl_q;
    // Data edges while the clock line stays high mark start and stop.
    assign start_evt = scl_lvl & scl_q &  sda_q & ~sda_lvl;
    assign stop_evt  = scl_lvl & scl_q & ~sda_q &  sda_lvl;

endmodule

// File: rtl/sermem_page_buf.sv
module sermem_page_buf #(
    parameter int PAGE_BYTES = 16,
    localparam int IDX_W = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);

    logic [7:0]            slot_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] slot_vld;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
        logic [7:0] d_q;
        logic       v_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (clr) begin
                v_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                d_q <= wr_data;
                v_q <= 1'b1;
            end
        end
        assign slot_data[i] = d_q;
        assign slot_vld[i]  = v_q;
    end

    assign rd_data   = slot_data[rd_idx];
    assign rd_valid  = slot_vld[rd_idx];
    assign any_valid = |slot_vld;

endmodule

// File: rtl/sermem_commit.sv
module sermem_commit #(
    parameter int PAGE_BYTES = 16,
    parameter int WR_CYCLES  = 250000,
    localparam int IDX_W = $clog2(PAGE_BYTES),
    localparam int CW    = $clog2(WR_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             step_we,
    output logic [IDX_W-1:0] step_idx
);

    localparam logic [CW-1:0] LAST  = CW'(WR_CYCLES - 1);
    localparam logic [CW-1:0] SLOTS = CW'(PAGE_BYTES);
    localparam logic [CW-1:0] C_ONE = CW'(1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                cnt_q <= '0;
            end
        end else if (cnt_q == LAST) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q + C_ONE;
        end
    end

    // One page slot is copied per clock in the first PAGE_BYTES cycles.
    assign done     = busy && (cnt_q == LAST);
    assign step_we  = busy && (cnt_q < SLOTS);
    assign step_idx = cnt_q[IDX_W-1:0];

    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy);

    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

// File: rtl/sermem_array.sv
module sermem_array #(
    parameter int ADDR_W = 11,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/sermem_slave.sv
module sermem_slave
    import sermem_pkg::*;
#(
    parameter int PAGE_BYTES  = 16,
    parameter int WR_CYCLES   = 250000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe_o
);

    localparam int ADDR_W = 8 + BLK_W;
    localparam int IDX_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - IDX_W;
    localparam logic [ADDR_W-1:0] A_ONE   = ADDR_W'(1);
    localparam logic [IDX_W-1:0]  IDX_ONE = IDX_W'(1);

    // Bus front end
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;

    sermem_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    bus_state_t        state_q, state_d;
    logic [3:0]        bitcnt_q;
    logic [7:0]        shreg_q;
    logic              rw_q;
    logic [BLK_W-1:0]  blk_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              mack_q;
    logic [PAGE_W-1:0] page_base_q;

    logic busy, cm_done, step_we;
    logic [IDX_W-1:0] step_idx;
    logic [7:0] buf_rd_data, arr_rd_data;
    logic buf_rd_valid, any_valid;

    // Decoded conditions
    logic rx_state, in_write, ctrl_ok;
    logic ctrl_accept, addr_done, byte_done, enter_tx;
    logic commit_req, cm_start, buf_clr, arr_we;

    assign rx_state = (state_q == ST_CTRL) || (state_q == ST_ADDR) || (state_q == ST_WDAT);
    assign in_write = (state_q == ST_WDAT) || (state_q == ST_DACK);
    assign ctrl_ok  = (shreg_q[7:4] == DEV_TAG) && !busy;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_CTRL;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_CTRL: if (scl_fall && bitcnt_q == 4'd8) state_d = ctrl_ok ? ST_CACK : ST_SKIP;
                ST_CACK: if (scl_fall) state_d = rw_q ? ST_TX : ST_ADDR;
                ST_ADDR: if (scl_fall && bitcnt_q == 4'd8) state_d = ST_AACK;
                ST_AACK: if (scl_fall) state_d = ST_WDAT;
                ST_WDAT: if (scl_fall && bitcnt_q == 4'd8) state_d = ST_DACK;
                ST_DACK: if (scl_fall) state_d = ST_WDAT;
                ST_TX:   if (scl_fall && bitcnt_q == 4'd7) state_d = ST_RACK;
                ST_RACK: if (scl_fall) state_d = mack_q ? ST_SKIP : ST_TX;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output decode: drive low for acknowledges and for zero data bits.
    always_comb begin
        sda_oe_o = 1'b0;
        unique case (state_q)
            ST_CACK, ST_AACK, ST_DACK: sda_oe_o = 1'b1;
            ST_TX:                     sda_oe_o = ~shreg_q[7];
            default:                   sda_oe_o = 1'b0;
        endcase
    end

    assign ctrl_accept = (state_q == ST_CTRL) && (state_d == ST_CACK);
    assign addr_done   = (state_q == ST_ADDR) && (state_d == ST_AACK);
    assign byte_done   = (state_q == ST_WDAT) && (state_d == ST_DACK);
    assign enter_tx    = (state_d == ST_TX) && (state_q != ST_TX);

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            rw_q        <= 1'b0;
            blk_q       <= '0;
            ptr_q       <= '0;
            mack_q      <= 1'b1;
            page_base_q <= '0;
        end else begin
            if (state_d != state_q) begin
                bitcnt_q <= '0;
            end else if ((rx_state && scl_rise) || (state_q == ST_TX && scl_fall)) begin
                bitcnt_q <= bitcnt_q + 4'd1;
            end

            if (enter_tx) begin
                shreg_q <= arr_rd_data;
            end else if (rx_state && scl_rise) begin
                shreg_q <= {shreg_q[6:0], sda_lvl};
            end else if (state_q == ST_TX && scl_fall) begin
                shreg_q <= {shreg_q[6:0], 1'b1};
            end

            if (ctrl_accept) begin
                rw_q  <= shreg_q[0];
                blk_q <= shreg_q[BLK_W:1];
                if (shreg_q[0]) begin
                    ptr_q[ADDR_W-1 -: BLK_W] <= shreg_q[BLK_W:1];
                end
            end else if (addr_done) begin
                ptr_q <= {blk_q, shreg_q};
            end else if (byte_done) begin
                ptr_q[IDX_W-1:0] <= ptr_q[IDX_W-1:0] + IDX_ONE;
            end else if (enter_tx) begin
                ptr_q <= ptr_q + A_ONE;
            end

            if (state_q == ST_RACK && scl_rise) begin
                mack_q <= sda_lvl;
            end

            if (cm_start) begin
                page_base_q <= ptr_q[ADDR_W-1:IDX_W];
            end
        end
    end

    // Commit control
    assign commit_req = stop_evt && in_write && any_valid;
    assign cm_start   = commit_req && !wp_i && !busy;
    assign buf_clr    = (commit_req && wp_i) || cm_done || (start_evt && in_write);
    assign arr_we     = step_we && buf_rd_valid;

    sermem_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .wr_en     (byte_done),
        .wr_idx    (ptr_q[IDX_W-1:0]),
        .wr_data   (shreg_q),
        .rd_idx    (step_idx),
        .rd_data   (buf_rd_data),
        .rd_valid  (buf_rd_valid),
        .any_valid (any_valid)
    );

    sermem_commit #(.PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)) u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cm_start),
        .busy     (busy),
        .done     (cm_done),
        .step_we  (step_we),
        .step_idx (step_idx)
    );

    sermem_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .wr_en   (arr_we),
        .wr_addr ({page_base_q, step_idx}),
        .wr_data (buf_rd_data),
        .rd_addr (ptr_q),
        .rd_data (arr_rd_data)
    );

    // R2: drive changes only while the clock line is low
    a_r2_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) && !$past(start_evt) && !$past(stop_evt) |-> !$past(scl_lvl));

    // R2: a stop always frees the state machine
    a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> state_q == ST_IDLE);

    // R8: control byte during a commit is refused
    a_r8_busy_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        busy && state_q == ST_CTRL && scl_fall && bitcnt_q == 4'd8 |=> state_q == ST_SKIP);

    // R9: protected stop starts no busy interval
    a_r9_wp_no_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt && wp_i && !busy |=> !busy);

    // R7: array is written only inside a busy interval
    a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: tb/sim_sermem_slave.sv
module sim_sermem_slave;

    localparam int WRC = 2000;
    localparam int Q   = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    sermem_slave #(.PAGE_BYTES(16), .WR_CYCLES(WRC), .SYNC_STAGES(2)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .wp_i     (wp),
        .sda_oe_o (sda_oe)
    );

    // {address[10:0], data[7:0]} for single-byte writes
    localparam logic [18:0] VEC [6] = '{
        {11'h7FF, 8'hE7}, {11'h000, 8'h0E}, {11'h001, 8'hC3},
        {11'h155, 8'h5A}, {11'h3A0, 8'hA0}, {11'h6C2, 8'h2C}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input logic master_ack, output logic [7:0] b);
        sda_m = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            scl_m = 1'b0;
        end
        put_bit(~master_ack);
    endtask

    function automatic logic [7:0] ctl(input logic [10:0] a, input logic rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    task automatic wr_txn(input logic [10:0] a, input int n, input logic [7:0] d0,
                          output logic all_ack);
        logic k;
        all_ack = 1'b1;
        bus_start();
        put_byte(ctl(a, 1'b0), k); all_ack &= k;
        put_byte(a[7:0], k);       all_ack &= k;
        for (int i = 0; i < n; i++) begin
            put_byte(d0 + 8'(i), k); all_ack &= k;
        end
        bus_stop();
    endtask

    task automatic rd_start(input logic [10:0] a, output logic ok);
        logic k;
        ok = 1'b1;
        bus_start();
        put_byte(ctl(a, 1'b0), k); ok &= k;
        put_byte(a[7:0], k);       ok &= k;
        bus_start();
        put_byte(ctl(a, 1'b1), k); ok &= k;
    endtask

    task automatic poll_busy(input logic [10:0] a, input string req);
        logic k;
        bus_start();
        put_byte(ctl(a, 1'b0), k);
        chk(req, 32'(k), 32'd0);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (run did not complete) actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic ok;
        logic [7:0] b;
        logic [7:0] exp;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: released line after reset
        chk("R1 line released after reset", 32'(sda_oe), 32'd0);

        // R4: wrong device tag is ignored
        bus_start();
        put_byte(8'hB0, ok);
        chk("R4 wrong tag not acknowledged", 32'(ok), 32'd0);
        bus_stop();
        chk("R2 line released after stop", 32'(sda_oe), 32'd0);

        // Vector table: byte writes, busy poll, random read back
        for (int v = 0; v < 6; v++) begin
            wr_txn(VEC[v][18:8], 1, VEC[v][7:0], ok);
            chk("R3 R5 write bytes acknowledged", 32'(ok), 32'd1);
            poll_busy(VEC[v][18:8], "R8 control refused while busy");
            tick(WRC + 100);
            rd_start(VEC[v][18:8], ok);
            chk("R8 R10 control acknowledged after commit", 32'(ok), 32'd1);
            get_byte(1'b0, b);
            chk("R5 R10 random read data", 32'(b), 32'(VEC[v][7:0]));
            bus_stop();
        end

        // R11: sequential read across the top of memory
        rd_start(11'h7FF, ok);
        get_byte(1'b1, b);
        chk("R11 byte at 0x7FF", 32'(b), 32'hE7);
        get_byte(1'b0, b);
        chk("R11 wrap to 0x000", 32'(b), 32'h0E);
        bus_stop();

        // R12: not-acknowledge ends read, pointer kept for current read
        rd_start(11'h000, ok);
        get_byte(1'b0, b);
        chk("R12 first byte", 32'(b), 32'h0E);
        bus_stop();
        chk("R12 line released after read stop", 32'(sda_oe), 32'd0);
        bus_start();
        put_byte(8'hA1, ok);
        chk("R12 current read control acknowledged", 32'(ok), 32'd1);
        get_byte(1'b0, b);
        chk("R12 current read continues at 0x001", 32'(b), 32'hC3);
        bus_stop();

        // R6: eighteen bytes from offset 5 of page 0x230
        wr_txn(11'h235, 18, 8'h40, ok);
        chk("R6 page data acknowledged", 32'(ok), 32'd1);
        poll_busy(11'h235, "R7 page commit busy");
        tick(WRC + 100);
        rd_start(11'h230, ok);
        chk("R6 read control acknowledged", 32'(ok), 32'd1);
        for (int i = 0; i < 16; i++) begin
            int k;
            k = (i - 5) & 15;
            exp = (k < 2) ? 8'(8'h50 + k) : 8'(8'h40 + k);
            get_byte(i != 15, b);
            chk("R6 page slot", 32'(b), 32'(exp));
        end
        bus_stop();

        // R7: single byte into a full page leaves neighbours alone
        wr_txn(11'h233, 1, 8'hA5, ok);
        tick(WRC + 100);
        rd_start(11'h232, ok);
        get_byte(1'b1, b);
        chk("R7 lower neighbour kept", 32'(b), 32'h4D);
        get_byte(1'b1, b);
        chk("R7 written slot", 32'(b), 32'hA5);
        get_byte(1'b0, b);
        chk("R7 upper neighbour kept", 32'(b), 32'h4F);
        bus_stop();

        // R9: write protect discards data and starts no busy interval
        wp = 1'b1;
        wr_txn(11'h233, 1, 8'h11, ok);
        chk("R9 protected data still acknowledged", 32'(ok), 32'd1);
        rd_start(11'h233, ok);
        chk("R9 no busy after protected stop", 32'(ok), 32'd1);
        get_byte(1'b0, b);
        chk("R9 array unchanged", 32'(b), 32'hA5);
        bus_stop();
        wp = 1'b0;

        tick(20);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule